// File: doc/BRIEF.md
# Link-to-memory FIS receive router

This block receives frames word by word from a link-layer receive port, decides from the first word whether each frame carries bulk payload or control content, and writes the frame into system memory through a wide burst-write port. The first word of every frame is classified. A bulk-payload frame loses that header word and lands in the payload area. Every other frame is stored unchanged, header included, in the control area. Both areas have their base addresses supplied on input ports.

Incoming words are gathered into wide beats and queued in a beat FIFO. When a frame ends partway through a burst, zero words are appended until the frame fills a whole number of fixed-length bursts. A burst engine sends one address request as soon as a full burst is queued, then streams that burst's beats. Once the final padded beat of a frame is queued, a one-cycle interrupt reports the stored word count and the frame kind. Firmware reads these to decode what arrived.

Top module: `fis_rx_router`

## Requirements
- R1: A frame whose first word has bits [7:0] equal to 0x46 is a payload frame (reported flag 1). Any other value makes it a control frame (flag 0).
- R2: The first burst of each frame is addressed at `pay_base` for payload frames and at `ctl_base` for control frames. Each further burst of the same frame is addressed 512 bytes above the previous one.
- R3: The header word of a payload frame is never written to memory. A control frame is written whole, with its header as stored word 0.
- R4: Stored word k of a frame sits in beat k/8 of the frame, bits [32*(k%8)+31 : 32*(k%8)].
- R5: Every burst is one address handshake followed by exactly 16 beats of 256 bits. `mem_wlast` is high on the 16th beat only, and address and beat phases never overlap.
- R6: After the last stored word, zero words are appended up to the next multiple of 128 words (16 beats). A payload frame with only a header produces no burst.
- R7: An address request is raised only when at least one full burst is queued. The number of bursts per frame is the padded word count divided by 128, and the request address stays stable until accepted.
- R8: After the last beat of a frame is queued, `rx_irq` is high for exactly one cycle. `rx_word_count` then gives the stored word count, excluding the stripped header and the padding, and `rx_frame_is_pay` gives the kind. Both hold until the next report.
- R9: `rx_ready` is low in the cycle after the last word of a frame is accepted, and while the beat FIFO is full. No word is lost or reordered when the memory side stalls.
- R10: After reset no address or beat request is active, `rx_irq` is low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | 32 | Receive word |
| rx_last | input | 1 | Marks the final word of a frame |
| rx_ready | output | 1 | Block accepts the receive word this cycle |
| pay_base | input | 32 | Base byte address of the payload area |
| ctl_base | input | 32 | Base byte address of the control area |
| mem_awvalid | output | 1 | Burst address request |
| mem_awready | input | 1 | Burst address accepted |
| mem_awaddr | output | 32 | Burst start byte address |
| mem_wvalid | output | 1 | Beat valid |
| mem_wready | input | 1 | Beat accepted |
| mem_wdata | output | 256 | Beat data |
| mem_wlast | output | 1 | Final beat of a burst |
| rx_irq | output | 1 | One-cycle end-of-frame report |
| rx_word_count | output | 24 | Stored word count of the last reported frame |
| rx_frame_is_pay | output | 1 | Kind of the last reported frame (1 payload) |

## Verification
Two functions often share a cycle: the packer queues a freshly filled beat, and the burst engine removes the oldest beat for the memory side. Both act on the FIFO level in the same clock. A long control frame sent with the memory side always ready provokes this, because payload keeps arriving while earlier bursts drain. A long payload frame sent with both memory handshakes throttled presses the FIFO to full and stalls the receive port. The result is judged at the ports: every captured beat must equal the word stream predicted from the frame contents, with the exact padding, and the burst addresses and counts must match the frame length.

// File: rtl/fis_rx_pkg.sv
package fis_rx_pkg;
   localparam int unsigned FIS_TYPE_W = 8;

   typedef enum logic [1:0] {
      PK_RECV,
      PK_PAD,
      PK_DONE
   } pk_state_t;

   typedef enum logic [1:0] {
      BW_IDLE,
      BW_ADDR,
      BW_DATA
   } bw_state_t;
endpackage

// File: rtl/fis_rx_packer.sv
module fis_rx_packer
   import fis_rx_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned BEAT_W    = 256,
   parameter int unsigned BURST_LEN = 16,
   parameter int unsigned CNT_W     = 24,
   parameter logic [FIS_TYPE_W-1:0] DATA_CODE = 8'h46
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [WORD_W-1:0] rx_data,
   input  logic              rx_last,
   output logic              rx_ready,
   input  logic              fifo_full,
   output logic              push,
   output logic [BEAT_W+1:0] push_entry,
   output logic              irq,
   output logic [CNT_W-1:0]  rep_count,
   output logic              rep_is_pay
);
   localparam int unsigned LANES  = BEAT_W / WORD_W;
   localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int unsigned BC_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

   if (BEAT_W % WORD_W != 0) begin : g_bad_ratio
      $error("beat width must be a multiple of the word width");
   end
   if ((LANES & (LANES - 1)) != 0 || LANES < 2) begin : g_bad_lanes
      $error("words per beat must be a power of two, at least 2");
   end
   if ((BURST_LEN & (BURST_LEN - 1)) != 0 || BURST_LEN < 2) begin : g_bad_burst
      $error("burst length must be a power of two, at least 2");
   end

   pk_state_t         st_q;
   logic [LANE_W-1:0] lane_q;
   logic [BC_W-1:0]   beat_q;
   logic [BEAT_W-1:0] acc_q;
   logic [BEAT_W-1:0] merged;
   logic              first_q;
   logic              is_pay_q;
   logic              head_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              take;
   logic              keep;
   logic              hdr_pay;
   logic              pad_need;
   logic              lane_full;
   logic              cur_pay;

   always_comb begin
      rx_ready  = (st_q == PK_RECV) && !fifo_full;
      take      = rx_valid && rx_ready;
      hdr_pay   = rx_data[FIS_TYPE_W-1:0] == DATA_CODE;
      keep      = take && !(first_q && hdr_pay);
      pad_need  = (lane_q != '0) || (beat_q != '0);
      lane_full = lane_q == LANE_W'(LANES - 1);
      cur_pay   = (st_q == PK_RECV && first_q) ? hdr_pay : is_pay_q;
      push      = (keep && lane_full) ||
                  (st_q == PK_PAD && pad_need && !fifo_full);
      push_entry = {head_q, cur_pay, merged};
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*WORD_W +: WORD_W] =
         (keep && lane_q == LANE_W'(l)) ? rx_data : acc_q[l*WORD_W +: WORD_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= PK_RECV;
         lane_q     <= '0;
         beat_q     <= '0;
         acc_q      <= '0;
         first_q    <= 1'b1;
         is_pay_q   <= 1'b0;
         head_q     <= 1'b1;
         cnt_q      <= '0;
         irq        <= 1'b0;
         rep_count  <= '0;
         rep_is_pay <= 1'b0;
      end else begin
         irq <= 1'b0;
         case (st_q)
            PK_RECV: begin
               if (take) begin
                  first_q <= rx_last;
                  if (first_q) begin
                     is_pay_q <= hdr_pay;
                     cnt_q    <= keep ? CNT_W'(1) : '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
                  if (keep) lane_q <= lane_q + 1'b1;
                  if (rx_last) st_q <= PK_PAD;
               end
            end
            PK_PAD: begin
               if (push) lane_q <= '0;
               if (!pad_need) begin
                  st_q       <= PK_DONE;
                  irq        <= 1'b1;
                  rep_count  <= cnt_q;
                  rep_is_pay <= is_pay_q;
               end
            end
            default: begin
               st_q   <= PK_RECV;
               head_q <= 1'b1;
            end
         endcase
         if (push) begin
            acc_q  <= '0;
            beat_q <= beat_q + 1'b1;
            head_q <= 1'b0;
         end else if (keep) begin
            acc_q <= merged;
         end
      end
   end

   assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   assert_frame_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (beat_q == '0 && lane_q == '0));
   assert_head_at_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && head_q) |-> beat_q == '0);
   assert_stall_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (take && rx_last) |=> !rx_ready);
endmodule

// File: rtl/fis_rx_beat_fifo.sv
module fis_rx_beat_fifo #(
   parameter int unsigned ENTRY_W = 258,
   parameter int unsigned DEPTH   = 32,
   parameter int unsigned LVL_W   = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [ENTRY_W-1:0] push_data,
   input  logic               pop,
   output logic [ENTRY_W-1:0] head,
   output logic [LVL_W-1:0]   level,
   output logic               full
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("FIFO depth must be a power of two, at least 2");
   end

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]   wr_q;
   logic [PTR_W-1:0]   rd_q;

   assign head = mem[rd_q];
   assign full = level == LVL_W'(DEPTH);

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         level <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> level != '0);
endmodule

// File: rtl/fis_rx_burst_writer.sv
module fis_rx_burst_writer
   import fis_rx_pkg::*;
#(
   parameter int unsigned BEAT_W    = 256,
   parameter int unsigned BURST_LEN = 16,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned LVL_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  level,
   input  logic              head_first,
   input  logic              head_is_pay,
   input  logic [BEAT_W-1:0] head_data,
   output logic              pop,
   input  logic [ADDR_W-1:0] pay_base,
   input  logic [ADDR_W-1:0] ctl_base,
   output logic              aw_valid,
   input  logic              aw_ready,
   output logic [ADDR_W-1:0] aw_addr,
   output logic              w_valid,
   input  logic              w_ready,
   output logic [BEAT_W-1:0] w_data,
   output logic              w_last
);
   localparam int unsigned BC_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
   localparam logic [ADDR_W-1:0] BURST_BYTES = ADDR_W'(BURST_LEN * BEAT_W / 8);

   bw_state_t         st_q;
   logic [BC_W-1:0]   cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] next_q;
   logic              burst_ready;

   always_comb begin
      burst_ready = level >= LVL_W'(BURST_LEN);
      aw_valid    = st_q == BW_ADDR;
      aw_addr     = addr_q;
      w_valid     = st_q == BW_DATA;
      w_data      = head_data;
      w_last      = w_valid && cnt_q == BC_W'(BURST_LEN - 1);
      pop         = w_valid && w_ready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= BW_IDLE;
         cnt_q  <= '0;
         addr_q <= '0;
         next_q <= '0;
      end else begin
         case (st_q)
            BW_IDLE: begin
               if (burst_ready) begin
                  if (head_first) addr_q <= head_is_pay ? pay_base : ctl_base;
                  else            addr_q <= next_q;
                  st_q <= BW_ADDR;
               end
            end
            BW_ADDR: begin
               if (aw_ready) begin
                  next_q <= addr_q + BURST_BYTES;
                  cnt_q  <= '0;
                  st_q   <= BW_DATA;
               end
            end
            default: begin
               if (w_ready) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (w_last) st_q <= BW_IDLE;
               end
            end
         endcase
      end
   end

   assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_addr)));
   assert_full_burst_queued_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (aw_valid && !$past(aw_valid)) |-> $past(level) >= LVL_W'(BURST_LEN));
   assert_phases_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(aw_valid && w_valid));
   assert_beat_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (w_valid && !w_ready) |=> (w_valid && $stable(w_data)));
endmodule

// File: rtl/fis_rx_router.sv
module fis_rx_router
   import fis_rx_pkg::*;
#(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned BEAT_W     = 256,
   parameter int unsigned BURST_LEN  = 16,
   parameter int unsigned FIFO_DEPTH = 32,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned CNT_W      = 24,
   parameter logic [FIS_TYPE_W-1:0] DATA_CODE = 8'h46
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [WORD_W-1:0] rx_data,
   input  logic              rx_last,
   output logic              rx_ready,
   input  logic [ADDR_W-1:0] pay_base,
   input  logic [ADDR_W-1:0] ctl_base,
   output logic              mem_awvalid,
   input  logic              mem_awready,
   output logic [ADDR_W-1:0] mem_awaddr,
   output logic              mem_wvalid,
   input  logic              mem_wready,
   output logic [BEAT_W-1:0] mem_wdata,
   output logic              mem_wlast,
   output logic              rx_irq,
   output logic [CNT_W-1:0]  rx_word_count,
   output logic              rx_frame_is_pay
);
   localparam int unsigned ENTRY_W = BEAT_W + 2;
   localparam int unsigned LVL_W   = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH < BURST_LEN) begin : g_bad_fifo
      $error("FIFO must hold at least one full burst");
   end

   logic               push;
   logic               pop;
   logic               full;
   logic [ENTRY_W-1:0] push_entry;
   logic [ENTRY_W-1:0] head;
   logic [LVL_W-1:0]   level;

   fis_rx_packer #(
      .WORD_W(WORD_W), .BEAT_W(BEAT_W), .BURST_LEN(BURST_LEN),
      .CNT_W(CNT_W), .DATA_CODE(DATA_CODE)
   ) u_packer (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
      .rx_ready(rx_ready), .fifo_full(full),
      .push(push), .push_entry(push_entry),
      .irq(rx_irq), .rep_count(rx_word_count), .rep_is_pay(rx_frame_is_pay)
   );

   fis_rx_beat_fifo #(
      .ENTRY_W(ENTRY_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
   ) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_data(push_entry), .pop(pop),
      .head(head), .level(level), .full(full)
   );

   fis_rx_burst_writer #(
      .BEAT_W(BEAT_W), .BURST_LEN(BURST_LEN), .ADDR_W(ADDR_W), .LVL_W(LVL_W)
   ) u_writer (
      .clk(clk), .rst_n(rst_n),
      .level(level), .head_first(head[BEAT_W+1]), .head_is_pay(head[BEAT_W]),
      .head_data(head[BEAT_W-1:0]), .pop(pop),
      .pay_base(pay_base), .ctl_base(ctl_base),
      .aw_valid(mem_awvalid), .aw_ready(mem_awready), .aw_addr(mem_awaddr),
      .w_valid(mem_wvalid), .w_ready(mem_wready), .w_data(mem_wdata),
      .w_last(mem_wlast)
   );
endmodule

// File: tb/fis_rx_router_tb.sv
module fis_rx_router_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rx_valid = 1'b0;
   logic [31:0]  rx_data = '0;
   logic         rx_last = 1'b0;
   logic         rx_ready;
   logic [31:0]  pay_base = 32'h1000_0000;
   logic [31:0]  ctl_base = 32'h0000_2000;
   logic         mem_awvalid;
   logic         mem_awready = 1'b0;
   logic [31:0]  mem_awaddr;
   logic         mem_wvalid;
   logic         mem_wready = 1'b0;
   logic [255:0] mem_wdata;
   logic         mem_wlast;
   logic         rx_irq;
   logic [23:0]  rx_word_count;
   logic         rx_frame_is_pay;

   always #5 clk = ~clk;

   fis_rx_router u_dut (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
      .pay_base(pay_base), .ctl_base(ctl_base),
      .mem_awvalid(mem_awvalid), .mem_awready(mem_awready), .mem_awaddr(mem_awaddr),
      .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_wdata(mem_wdata),
      .mem_wlast(mem_wlast),
      .rx_irq(rx_irq), .rx_word_count(rx_word_count), .rx_frame_is_pay(rx_frame_is_pay)
   );

   int nvec = 0;
   int nfail = 0;
   int stall_mode = 0;
   int cyc = 0;
   logic [255:0] cap_beat [0:1023];
   logic         cap_last [0:1023];
   logic [31:0]  cap_addr [0:127];
   int nb = 0;
   int na = 0;
   int nirq = 0;
   logic [23:0] irq_cnt = '0;
   logic        irq_pay = 1'b0;

   // memory-side model: set readies away from the edge, then log handshakes
   always @(negedge clk) begin
      cyc++;
      if (stall_mode == 0) begin
         mem_awready = 1'b1;
         mem_wready  = 1'b1;
      end else begin
         mem_awready = (cyc % 4) == 0;
         mem_wready  = (cyc % 3) != 0;
      end
      #1;
      if (rst_n) begin
         if (mem_awvalid && mem_awready && na < 128) begin
            cap_addr[na] = mem_awaddr;
            na++;
         end
         if (mem_wvalid && mem_wready && nb < 1024) begin
            cap_beat[nb] = mem_wdata;
            cap_last[nb] = mem_wlast;
            nb++;
         end
         if (rx_irq) begin
            nirq++;
            irq_cnt = rx_word_count;
            irq_pay = rx_frame_is_pay;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] hdr_word(input int fid, input bit pay);
      logic [31:0] f = fid;
      return {8'h00, f[7:0], 8'h00, (pay ? 8'h46 : 8'h34)};
   endfunction

   function automatic logic [31:0] pword(input int fid, input int k);
      logic [31:0] f = fid;
      logic [31:0] kk = k;
      return {8'hA5, f[7:0], kk[15:0]};
   endfunction

   // expected stored word k (R3: payload header dropped, control header kept)
   function automatic logic [31:0] exp_word(input int fid, input bit pay, input int k);
      if (pay) return pword(fid, k);
      if (k == 0) return hdr_word(fid, pay);
      return pword(fid, k - 1);
   endfunction

   task automatic send_frame(input int fid, input bit pay, input int npay);
      int total = npay + 1;
      for (int i = 0; i < total; i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_data  = (i == 0) ? hdr_word(fid, pay) : pword(fid, i - 1);
         rx_last  = (i == total - 1);
         while (!rx_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      rx_valid = 1'b0;
      rx_last  = 1'b0;
      chk(rx_ready == 1'b0, "R9", "rx_ready after last word", rx_ready, 0);
   endtask

   task automatic run_frame(input int fid, input bit pay, input int npay);
      int nb0 = nb;
      int na0 = na;
      int ni0 = nirq;
      int stored = pay ? npay : npay + 1;
      int expbeats = ((stored + 127) / 128) * 16;
      int bad_addr = 0;
      int bad_pay = 0;
      int bad_pad = 0;
      int bad_last = 0;
      logic [31:0] base = pay ? pay_base : ctl_base;
      send_frame(fid, pay, npay);
      for (int t = 0; t < 3000 && nirq == ni0; t++) @(negedge clk);
      for (int t = 0; t < 5000 && (nb - nb0) < expbeats; t++) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(nirq == ni0 + 1, "R8", "interrupt pulses", nirq - ni0, 1);
      chk(irq_cnt == 24'(stored), "R8", "reported word count", irq_cnt, stored);
      chk(irq_pay == pay, "R1", "reported frame kind", irq_pay, pay);
      chk(nb - nb0 == expbeats, "R6", "beats written", nb - nb0, expbeats);
      chk(na - na0 == expbeats / 16, "R7", "bursts requested", na - na0, expbeats / 16);
      if (nb - nb0 == expbeats && na - na0 == expbeats / 16) begin
         for (int b = 0; b < expbeats / 16; b++)
            if (cap_addr[na0 + b] != base + 32'(b * 512)) bad_addr++;
         for (int b = 0; b < expbeats; b++) begin
            if (cap_last[nb0 + b] != ((b % 16) == 15)) bad_last++;
            for (int l = 0; l < 8; l++) begin
               int k = b * 8 + l;
               logic [31:0] got = cap_beat[nb0 + b][32*l +: 32];
               if (k < stored) begin
                  if (got != exp_word(fid, pay, k)) bad_pay++;
               end else if (got != 32'h0) begin
                  bad_pad++;
               end
            end
         end
         chk(bad_addr == 0, "R2", "burst addresses wrong", bad_addr, 0);
         chk(bad_pay == 0, "R4", "stored words wrong (R3 strip)", bad_pay, 0);
         chk(bad_pad == 0, "R6", "padding words nonzero", bad_pad, 0);
         chk(bad_last == 0, "R5", "wlast misplaced", bad_last, 0);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(mem_awvalid == 1'b0, "R10", "awvalid at reset", mem_awvalid, 0);
      chk(mem_wvalid == 1'b0, "R10", "wvalid at reset", mem_wvalid, 0);
      chk(rx_irq == 1'b0, "R10", "irq at reset", rx_irq, 0);
      chk(rx_ready == 1'b1, "R10", "rx_ready at reset", rx_ready, 1);
   endtask

   task automatic t_short_control;  // R1 R3 control frame kept whole
      stall_mode = 0;
      run_frame(1, 1'b0, 4);
   endtask

   task automatic t_short_payload;  // R3 R6 header stripped, padded
      stall_mode = 0;
      run_frame(2, 1'b1, 20);
   endtask

   task automatic t_exact_burst;    // R6 no padding needed
      stall_mode = 0;
      run_frame(3, 1'b1, 128);
   endtask

   task automatic t_stalled_long;   // R9 FIFO fills under memory stalls
      stall_mode = 1;
      run_frame(4, 1'b1, 300);
      stall_mode = 0;
   endtask

   task automatic t_header_only;    // R6 empty payload frame
      stall_mode = 0;
      run_frame(5, 1'b1, 0);
   endtask

   task automatic t_long_control;   // R2 second burst +512, push/pop overlap
      stall_mode = 0;
      run_frame(6, 1'b0, 139);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: run did not complete, actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_short_control();
      t_short_payload();
      t_exact_burst();
      t_stalled_long();
      t_header_only();
      t_long_control();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule